// File: doc/BRIEF.md
# Read Request Splitter with Tags

This block turns one large DMA read command into a stream of memory read request descriptors. A command is a 64-bit byte address and a byte length of up to 4 GB. The block cuts it into consecutive requests. None is larger than a programmable maximum read size, and none crosses a 4 KB address boundary. Each request gets a tag drawn from a finite pool so that its completions can be matched to it later.

Requests leave on a valid/ready handshake carrying a dword address, a length in dwords and a tag. A tag returns to the pool when the completion logic pulses `cpl_done` with that tag. When every tag is outstanding, the block stalls. When the last request of a command has been accepted and every tag has come back, `cmd_done` pulses and the block accepts its next command.

Top module: `rd_req_splitter`

## Requirements
- R1: `cmd_mrrs` is sampled when a command is accepted. It sets the largest request: 0 gives 128 bytes, 1 gives 256, 2 gives 512, 3 gives 1024, 4 gives 2048 and 5 gives 4096 bytes (32, 64, 128, 256, 512 and 1024 dwords).
- R2: The codes 6 and 7 behave as code 0, so the largest request is 128 bytes.
- R3: The requests of a command are contiguous. Each `req_addr` equals the previous `req_addr` plus four times the previous `req_dw`. Every request is of maximum size unless a 4 KB boundary or the end of the command cuts it short.
- R4: A request never crosses a 4 KB boundary. The low 12 bits of `req_addr` plus 4*`req_dw` never exceed 4096.
- R5: Bits 1:0 of `cmd_addr` are ignored. The total is ceil(`cmd_len`/4) dwords, and the last request carries the remainder. No request follows it.
- R6: Each issued tag is the lowest-numbered tag that is not outstanding. No outstanding tag is issued again.
- R7: `pending` rises by one for each accepted request and falls by one for each valid release.
- R8: While all TAGS tags are outstanding, `req_valid` is low. The cycle after a release, the released tag is offered.
- R9: `cmd_ready` is high only when the block is idle. `cmd_done` is a one-cycle pulse. It comes in the cycle after the edge at which the last request has been accepted and the last tag has returned. A zero-length command issues no request, and its done pulse comes in the cycle after acceptance.
- R10: A `cpl_done` pulse whose tag is not outstanding sets `tag_err` and leaves `pending` unchanged. `tag_err` stays set until reset.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_dw` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_addr | input | 64 | Start byte address |
| cmd_len | input | 33 | Length in bytes |
| cmd_mrrs | input | 3 | Maximum read size code |
| cmd_done | output | 1 | Command finished pulse |
| req_valid | output | 1 | Request descriptor present |
| req_ready | input | 1 | Downstream takes descriptor |
| req_addr | output | 64 | Request byte address, dword aligned |
| req_dw | output | 11 | Request length in dwords |
| req_tag | output | 5 | Request tag |
| cpl_done | input | 1 | Tag release pulse |
| cpl_tag | input | 5 | Tag being released |
| pending | output | 6 | Outstanding request count |
| tag_err | output | 1 | Sticky bad-release flag |

## Verification
A command accepted at one edge shows its first descriptor in the next cycle. A descriptor accepted at an edge is replaced by its successor in the next cycle. A release at an edge updates `pending`, `tag_err` and the offered tag in the next cycle. The done pulse follows one cycle after the final release. Every check samples on the falling edge that follows the rising edge that should have produced the result. Every input is driven on a falling edge, so each check sees the state after exactly one rising edge.

// File: rtl/rd_req_splitter.sv
module rd_req_splitter #(
  parameter int TAGS = 32,
  parameter int AW = 64,
  parameter int LW = 33,
  localparam int TW = $clog2(TAGS),
  localparam int CW = $clog2(TAGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [2:0]    cmd_mrrs,
  output logic          cmd_done,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [10:0]   req_dw,
  output logic [TW-1:0] req_tag,
  input  logic          cpl_done,
  input  logic [TW-1:0] cpl_tag,
  output logic [CW-1:0] pending,
  output logic          tag_err
);
  localparam int RW = LW - 1;

  logic            busy;
  logic [AW-3:0]   cur;
  logic [RW-1:0]   rem;
  logic [2:0]      code_q;
  logic [TAGS-1:0] outst;
  logic [10:0]     max_dw, to_bnd, lim, chunk;
  logic [TW-1:0]   pick;
  logic            any_free, issue, rel_ok;
  logic [LW:0]     len_ext;

  assign max_dw = (code_q <= 3'd5) ? (11'd32 << code_q) : 11'd32;
  assign to_bnd = 11'd1024 - {1'b0, cur[9:0]};
  assign lim    = (max_dw < to_bnd) ? max_dw : to_bnd;
  assign chunk  = (rem < RW'(lim)) ? rem[10:0] : lim;

  always_comb begin
    pick = '0;
    any_free = 1'b0;
    for (int i = TAGS - 1; i >= 0; i--)
      if (!outst[i]) begin
        pick = TW'(i);
        any_free = 1'b1;
      end
  end

  assign req_valid = busy && (rem != '0) && any_free;
  assign req_addr  = {cur, 2'b00};
  assign req_dw    = chunk;
  assign req_tag   = pick;
  assign issue     = req_valid && req_ready;
  assign rel_ok    = cpl_done && (32'(cpl_tag) < TAGS) && outst[cpl_tag];
  assign cmd_ready = !busy;
  assign cmd_done  = busy && (rem == '0) && (pending == '0);
  assign len_ext   = {1'b0, cmd_len} + (LW+1)'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur <= '0;
      rem <= '0;
      code_q <= '0;
    end else if (!busy) begin
      if (cmd_valid) begin
        busy <= 1'b1;
        cur <= cmd_addr[AW-1:2];
        rem <= len_ext[LW:2];
        code_q <= cmd_mrrs;
      end
    end else if (cmd_done) begin
      busy <= 1'b0;
    end else if (issue) begin
      cur <= cur + (AW-2)'(chunk);
      rem <= rem - RW'(chunk);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst <= '0;
      pending <= '0;
      tag_err <= 1'b0;
    end else begin
      for (int i = 0; i < TAGS; i++)
        if (issue && pick == TW'(i)) outst[i] <= 1'b1;
        else if (rel_ok && cpl_tag == TW'(i)) outst[i] <= 1'b0;
      pending <= pending + CW'(issue) - CW'(rel_ok);
      if (cpl_done && !rel_ok) tag_err <= 1'b1;
    end
  end

  a_r4_no_4k_cross: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({2'b0, req_addr[11:0]} + {1'b0, req_dw, 2'b00}) <= 14'd4096);
  a_r1_size_limit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_dw != 11'd0) && (req_dw <= 11'd1024));
  a_r6_tag_free: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !outst[req_tag]);
  a_r8_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pending) == TAGS) |-> !req_valid);
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pending) <= TAGS);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |=> tag_err);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done && cmd_ready);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_dw));
endmodule

// File: tb/rd_req_splitter_test.sv
module rd_req_splitter_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, req_ready = 1'b0, cpl_done = 1'b0;
  logic [63:0] cmd_addr = '0;
  logic [32:0] cmd_len = '0;
  logic [2:0]  cmd_mrrs = '0;
  logic [4:0]  cpl_tag = '0;
  logic cmd_ready, cmd_done, req_valid, tag_err;
  logic [63:0] req_addr;
  logic [10:0] req_dw;
  logic [4:0]  req_tag;
  logic [5:0]  pending;

  int vectors = 0, miscompares = 0;
  longint exp_a [0:63];
  int exp_d [0:63];
  int n_exp;

  rd_req_splitter uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string r, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic void build(longint addr, longint len, int code);
    longint a = addr & ~64'd3;
    longint rem = (len + 3) / 4;
    longint mx = (code <= 5) ? (32 << code) : 32;
    n_exp = 0;
    while (rem > 0) begin
      longint b = 1024 - ((a >> 2) & 1023);
      longint c = rem;
      if (c > mx) c = mx;
      if (c > b) c = b;
      exp_a[n_exp] = a;
      exp_d[n_exp] = int'(c);
      n_exp++;
      a += c * 4;
      rem -= c;
    end
  endfunction

  task automatic send(longint addr, longint len, int code);
    chk("R9 cmd_ready idle", cmd_ready, 1);
    build(addr, len, code);
    cmd_valid = 1'b1; cmd_addr = addr; cmd_len = 33'(len); cmd_mrrs = 3'(code);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic take(int first, int n, int base_tag);
    int i = first, guard = 0;
    req_ready = 1'b1;
    while (i < first + n && guard < 3000) begin
      if (req_valid) begin
        chk("R3 R4 R1 req_addr", req_addr, exp_a[i]);
        chk("R5 R1 req_dw", req_dw, exp_d[i]);
        chk("R6 req_tag", req_tag, base_tag + i - first);
        i++;
      end
      guard++;
      @(negedge clk);
    end
    req_ready = 1'b0;
    chk("R5 all requests seen", i, first + n);
  endtask

  task automatic rel(int t);
    cpl_done = 1'b1; cpl_tag = 5'(t);
    @(negedge clk);
    cpl_done = 1'b0;
  endtask

  task automatic finish_cmd(int n);
    chk("R7 pending after issue", pending, n);
    for (int t = 0; t < n; t++) begin
      chk("R9 no early done", cmd_done, 0);
      rel(t);
    end
    chk("R9 cmd_done pulse", cmd_done, 1);
    @(negedge clk);
    chk("R9 done one cycle", cmd_done, 0);
    chk("R9 ready again", cmd_ready, 1);
  endtask

  task automatic run_simple(longint addr, longint len, int code);
    send(addr, len, code);
    take(0, n_exp, 0);
    chk("R5 no extra request", req_valid, 0);
    finish_cmd(n_exp);
  endtask

  task automatic t_reset;
    chk("reset req_valid", req_valid, 0);
    chk("R9 reset cmd_ready", cmd_ready, 1);
    chk("R7 reset pending", pending, 0);
    chk("R10 reset tag_err", tag_err, 0);
  endtask

  task automatic t_split_hold;
    longint a0;
    int d0;
    send(64'h2000, 1000, 0);
    chk("R11 valid while held", req_valid, 1);
    a0 = req_addr; d0 = req_dw;
    @(negedge clk); @(negedge clk);
    chk("R11 valid held", req_valid, 1);
    chk("R11 addr held", req_addr, a0);
    chk("R11 dw held", req_dw, d0);
    take(0, n_exp, 0);
    chk("R5 eight pieces", n_exp, 8);
    chk("R5 last piece 26 dwords", exp_d[7], 26);
    finish_cmd(n_exp);
  endtask

  task automatic t_boundary;
    run_simple(64'h10_0000_0F00, 8192, 5);
    chk("R4 first cut at 4K", exp_d[0], 64);
  endtask

  task automatic t_codes;
    run_simple(64'h3, 300, 6);
    chk("R2 code 6 as 128B", exp_d[0], 32);
    run_simple(64'h4000, 200, 7);
    run_simple(64'h8000, 4096, 3);
    run_simple(64'h9000, 600, 2);
    run_simple(64'hA000, 256, 1);
    run_simple(64'h0, 4097, 4);
  endtask

  task automatic t_stall;
    send(64'h0, 40 * 128, 0);
    take(0, 32, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R8 stall valid low", req_valid, 0);
      chk("R7 pending full", pending, 32);
      @(negedge clk);
    end
    rel(5);
    chk("R8 resume valid", req_valid, 1);
    chk("R8 freed tag offered", req_tag, 5);
    chk("R3 resume addr", req_addr, exp_a[32]);
    chk("R7 pending after release", pending, 31);
    for (int t = 0; t < 32; t++) if (t != 5) rel(t);
    chk("R7 pending drained", pending, 0);
    take(32, 8, 0);
    finish_cmd(8);
  endtask

  task automatic t_bad_release;
    rel(3);
    chk("R10 tag_err set", tag_err, 1);
    chk("R10 pending unchanged", pending, 0);
    run_simple(64'h5000, 64, 0);
    chk("R10 tag_err sticky", tag_err, 1);
  endtask

  task automatic t_zero;
    send(64'h100, 0, 0);
    chk("R9 zero-length done", cmd_done, 1);
    chk("R5 zero-length no request", req_valid, 0);
    @(negedge clk);
    chk("R9 zero-length idle", cmd_ready, 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_hold();
    t_boundary();
    t_codes();
    t_stall();
    t_zero();
    t_bad_release();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule